// File: doc/BRIEF.md
# Vector Duplicate-Count and Last-Occurrence Unit

This execution unit serves a vector pipeline running a radix sort. It takes one source vector register of small keys, such as radix digits, and runs one of two operations on it. The count operation writes a result vector. Each element of that vector holds the number of lower-indexed elements that carry the same key. The last-occurrence operation writes a bit mask instead. A mask bit is set where an element holds the final copy of its key within the active part of the register.

A one-cycle `start` pulse loads the opcode, the active length and the packed source into the unit. The unit then works through the register in groups of `LANES` elements, one group per cycle. With `LANES = 1` it is the serial variant. A larger value gives the lockstepped multi-lane variant, which produces identical results. A one-cycle `done` marks completion, and the outputs stay unchanged until the next accepted start.

Top module: `vec_dup_count`

## Requirements
- R1: When `opSel = 0`, `resVec` element i (bits `[i*CNT_W +: CNT_W]`) equals the number of positions j < i whose key equals key i. Key i is `srcVec[i*ELEM_W +: ELEM_W]`.
- R2: When `opSel = 0`, the first occurrence of any key within the active length yields a count of 0.
- R3: When `opSel = 1`, `resMask` bit i is 1 exactly when no active position above i holds the same key as position i.
- R4: Positions at or above the active length read 0 in both `resVec` and `resMask`. A `vecLen` above `MAX_VL` is treated as `MAX_VL`.
- R5: The operation that is not selected leaves its own output all zero: the mask under `opSel = 0`, the result vector under `opSel = 1`.
- R6: `done` is high for exactly one cycle. It rises n clock edges after the edge that accepted `start`, where n = max(1, ceil(min(vecLen, MAX_VL) / LANES)).
- R7: A `start` that arrives while an operation is in progress is ignored. The running operation finishes with its own inputs and its own timing.
- R8: The multi-lane variant gives outputs bit-identical to the serial variant for every source and length.
- R9: After `done`, the outputs hold their values while `start` stays low, whatever the other inputs do.
- R10: Reset clears `resVec` and `resMask` to zero and holds `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opSel | input | 1 | 0 = count earlier equal keys, 1 = last-occurrence mask |
| vecLen | input | $clog2(MAX_VL+1) | Active vector length |
| srcVec | input | MAX_VL*ELEM_W | Packed source keys, element 0 in the low bits |
| resVec | output | MAX_VL*CNT_W | Packed counts, CNT_W = $clog2(MAX_VL) |
| resMask | output | MAX_VL | Last-occurrence mask |
| done | output | 1 | One-cycle completion pulse |

## Verification
After the edge that accepts `start`, `done` is due exactly max(1, ceil(len/LANES)) edges later. The bench counts rising edges after the accepting edge and samples one time unit past each edge. It records the first cycle in which `done` is seen and how many cycles it stays high. The output vectors are compared once the full window has passed, when both the serial and the three-lane instance are idle. They are compared again after further idle cycles in which the other inputs change, so late or spurious writes show up.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctl_t;
endpackage

// File: rtl/vdc_control.sv
module vdc_control #(
  parameter int MAX_VL = 16,
  parameter int LANES  = 1,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [VL_W-1:0]     vlIn,
  output vdc_pkg::ctl_t       ctl,
  output logic [VL_W-1:0]     grpIdx,
  output logic                done
);
  import vdc_pkg::*;

  state_t            stateQ;
  logic [VL_W-1:0]   grpQ;
  logic [VL_W-1:0]   numGrpQ;
  logic [VL_W:0]     roundUp;
  logic [VL_W-1:0]   numGrp;
  logic              lastGrp;

  assign roundUp = {1'b0, vlIn} + (VL_W+1)'(LANES - 1);
  assign numGrp  = VL_W'(roundUp / (VL_W+1)'(LANES));
  assign lastGrp = ({1'b0, grpQ} + (VL_W+1)'(1)) >= {1'b0, numGrpQ};

  assign ctl.load = (stateQ == ST_IDLE) && start;
  assign ctl.step = (stateQ == ST_RUN);
  assign grpIdx   = grpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      grpQ    <= '0;
      numGrpQ <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ  <= ST_RUN;
            grpQ    <= '0;
            numGrpQ <= numGrp;
          end
        end
        ST_RUN: begin
          if (lastGrp) begin
            stateQ <= ST_IDLE;
            done   <= 1'b1;
          end else begin
            grpQ <= grpQ + VL_W'(1);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a busy unit keeps running until its final group
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && !lastGrp) |=> (stateQ == ST_RUN));
endmodule

// File: rtl/vdc_datapath.sv
module vdc_datapath #(
  parameter int MAX_VL = 16,
  parameter int ELEM_W = 4,
  parameter int LANES  = 1,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int CNT_W  = $clog2(MAX_VL)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  vdc_pkg::ctl_t              ctl,
  input  logic [VL_W-1:0]            grpIdx,
  input  logic                       opIn,
  input  logic [VL_W-1:0]            vlIn,
  input  logic [MAX_VL*ELEM_W-1:0]   srcIn,
  output logic [MAX_VL*CNT_W-1:0]    resOut,
  output logic [MAX_VL-1:0]          maskOut
);
  localparam int NVAL  = 1 << ELEM_W;
  localparam int IDX_W = $clog2(MAX_VL);
  localparam int POS_W = $clog2(MAX_VL + LANES) + 1;

  logic [ELEM_W-1:0] srcQ   [MAX_VL];
  logic [CNT_W-1:0]  resQ   [MAX_VL];
  logic [CNT_W-1:0]  cntTab [NVAL];
  logic [NVAL-1:0]   seenQ;
  logic [MAX_VL-1:0] maskQ;
  logic [VL_W-1:0]   vlQ;
  logic              opQ;

  logic [POS_W-1:0]  lanePos [LANES];
  logic [IDX_W-1:0]  laneIdx [LANES];
  logic [ELEM_W-1:0] laneVal [LANES];
  logic              laneAct [LANES];
  logic [CNT_W-1:0]  laneCnt [LANES];
  logic              laneNew [LANES];

  // Per-lane addressing: ascending walk for counts, descending for the mask
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanePos[k] = POS_W'(grpIdx) * POS_W'(LANES) + POS_W'(k);
    assign laneAct[k] = lanePos[k] < POS_W'(vlQ);
    assign laneIdx[k] = IDX_W'(opQ ? (POS_W'(vlQ) - POS_W'(1) - lanePos[k])
                                   : lanePos[k]);
    assign laneVal[k] = laneAct[k] ? srcQ[laneIdx[k]] : '0;
  end

  // In-group pairwise compare against earlier-visited lanes
  always_comb begin
    logic [CNT_W-1:0] dupCnt;
    for (int k = 0; k < LANES; k++) begin
      dupCnt = '0;
      for (int j = 0; j < k; j++) begin
        if (laneAct[j] && (laneVal[j] == laneVal[k])) dupCnt = dupCnt + CNT_W'(1);
      end
      laneCnt[k] = cntTab[laneVal[k]] + dupCnt;
      laneNew[k] = !seenQ[laneVal[k]] && (dupCnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_VL; i++) begin
        srcQ[i] <= '0;
        resQ[i] <= '0;
      end
      for (int v = 0; v < NVAL; v++) cntTab[v] <= '0;
      seenQ <= '0;
      maskQ <= '0;
      vlQ   <= '0;
      opQ   <= 1'b0;
    end else if (ctl.load) begin
      for (int i = 0; i < MAX_VL; i++) begin
        srcQ[i] <= srcIn[i*ELEM_W +: ELEM_W];
        resQ[i] <= '0;
      end
      for (int v = 0; v < NVAL; v++) cntTab[v] <= '0;
      seenQ <= '0;
      maskQ <= '0;
      vlQ   <= vlIn;
      opQ   <= opIn;
    end else if (ctl.step) begin
      for (int k = 0; k < LANES; k++) begin
        if (laneAct[k]) begin
          if (!opQ) begin
            resQ[laneIdx[k]]   <= laneCnt[k];
            cntTab[laneVal[k]] <= laneCnt[k] + CNT_W'(1);
          end else begin
            maskQ[laneIdx[k]]  <= laneNew[k];
            seenQ[laneVal[k]]  <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < MAX_VL; i++) begin : g_pack
    assign resOut[i*CNT_W +: CNT_W] = resQ[i];
  end
  assign maskOut = maskQ;

  // Checker-side observation of held state
  logic tailBad;
  logic resAny;
  always_comb begin
    tailBad = 1'b0;
    resAny  = 1'b0;
    for (int i = 0; i < MAX_VL; i++) begin
      if (VL_W'(i) >= vlQ) tailBad = tailBad | (resQ[i] != '0) | maskQ[i];
      resAny = resAny | (resQ[i] != '0);
    end
  end

  // R4: nothing is ever written at or beyond the active length
  assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tailBad);

  // R5: only the selected operation's output may be non-zero
  assert_op_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opQ ? !resAny : (maskQ == '0)));

  // R1: a count can never exceed the number of lower positions
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && laneAct[0] && !opQ) |-> (CNT_W'(laneCnt[0]) <= CNT_W'(laneIdx[0])));

  // R3: at most one mark per active element
  assert_mask_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(maskQ) <= int'(vlQ));
endmodule

// File: rtl/vec_dup_count.sv
module vec_dup_count #(
  parameter  int MAX_VL = 16,
  parameter  int ELEM_W = 4,
  parameter  int LANES  = 1,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int CNT_W  = $clog2(MAX_VL)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      opSel,
  input  logic [VL_W-1:0]           vecLen,
  input  logic [MAX_VL*ELEM_W-1:0]  srcVec,
  output logic [MAX_VL*CNT_W-1:0]   resVec,
  output logic [MAX_VL-1:0]         resMask,
  output logic                      done
);
  vdc_pkg::ctl_t   ctl;
  logic [VL_W-1:0] grpIdx;
  logic [VL_W-1:0] vlEff;

  assign vlEff = (vecLen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vecLen;

  vdc_control #(.MAX_VL(MAX_VL), .LANES(LANES), .VL_W(VL_W)) u_control (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlEff),
    .ctl(ctl), .grpIdx(grpIdx), .done(done)
  );

  vdc_datapath #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W), .LANES(LANES),
                 .VL_W(VL_W), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .grpIdx(grpIdx), .opIn(opSel),
    .vlIn(vlEff), .srcIn(srcVec), .resOut(resVec), .maskOut(resMask)
  );
endmodule

// File: tb/test_vec_dup_count.sv
module test_vec_dup_count;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 8;
  localparam int ELEM_W = 3;
  localparam int CNT_W  = 3;
  localparam int VL_W   = 4;
  localparam int PLANES = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opSel = 1'b0;
  logic [VL_W-1:0] vecLen = '0;
  logic [MAX_VL*ELEM_W-1:0] srcVec = '0;
  logic [MAX_VL*CNT_W-1:0] resS, resP;
  logic [MAX_VL-1:0] maskS, maskP;
  logic doneS, doneP;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_dup_count #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W), .LANES(1)) i_vec_dup_count (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .vecLen(vecLen),
    .srcVec(srcVec), .resVec(resS), .resMask(maskS), .done(doneS));

  vec_dup_count #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W), .LANES(PLANES)) i_vec_dup_count_par (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .vecLen(vecLen),
    .srcVec(srcVec), .resVec(resP), .resMask(maskP), .done(doneP));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic op, input int vl, input logic [MAX_VL*ELEM_W-1:0] src,
                                output logic [MAX_VL*CNT_W-1:0] res, output logic [MAX_VL-1:0] msk);
    int n;
    n = (vl > MAX_VL) ? MAX_VL : vl;
    res = '0;
    msk = '0;
    for (int i = 0; i < n; i++) begin
      int c;
      bit later;
      c = 0;
      later = 0;
      for (int j = 0; j < i; j++)
        if (src[j*ELEM_W +: ELEM_W] == src[i*ELEM_W +: ELEM_W]) c++;
      for (int j = i + 1; j < n; j++)
        if (src[j*ELEM_W +: ELEM_W] == src[i*ELEM_W +: ELEM_W]) later = 1;
      if (!op) res[i*CNT_W +: CNT_W] = CNT_W'(c);
      else     msk[i] = !later;
    end
  endfunction

  function automatic int expLat(input int vl, input int lanes);
    int n;
    n = (vl > MAX_VL) ? MAX_VL : vl;
    return (n == 0) ? 1 : (n + lanes - 1) / lanes;
  endfunction

  task automatic runCase(input logic op, input int vl, input logic [MAX_VL*ELEM_W-1:0] src, input bit interfere);
    int firstS, firstP, hiS, hiP;
    logic [MAX_VL*CNT_W-1:0] eRes;
    logic [MAX_VL-1:0] eMsk;
    firstS = 0; firstP = 0; hiS = 0; hiP = 0;
    @(negedge clk);
    opSel = op; vecLen = VL_W'(vl); srcVec = src; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int cyc = 1; cyc <= 12; cyc++) begin
      if (interfere && cyc == 2) begin
        start = 1'b1; opSel = ~op; srcVec = ~src; vecLen = VL_W'(MAX_VL);
      end
      @(posedge clk); #1;
      if (interfere && cyc == 2) start = 1'b0;
      if (doneS) begin hiS++; if (firstS == 0) firstS = cyc; end
      if (doneP) begin hiP++; if (firstP == 0) firstP = cyc; end
    end
    model(op, vl, src, eRes, eMsk);
    // R6: serial and parallel timing, single-cycle pulse
    chk(firstS == expLat(vl, 1) && hiS == 1, interfere ? "R7 serial latency" : "R6 serial latency",
        32'(firstS * 16 + hiS), 32'(expLat(vl, 1) * 16 + 1));
    chk(firstP == expLat(vl, PLANES) && hiP == 1, interfere ? "R7 parallel latency" : "R6 parallel latency",
        32'(firstP * 16 + hiP), 32'(expLat(vl, PLANES) * 16 + 1));
    // R1 R2 R4 R5: counts; R3 R4 R5: mask
    chk(resS == eRes, "R1/R2/R4/R5 serial counts", 32'(resS), 32'(eRes));
    chk(maskS == eMsk, "R3/R4/R5 serial mask", 32'(maskS), 32'(eMsk));
    // R8: multi-lane bit-identical
    chk(resP == eRes && resP == resS, "R8 parallel counts", 32'(resP), 32'(eRes));
    chk(maskP == eMsk && maskP == maskS, "R8 parallel mask", 32'(maskP), 32'(eMsk));
  endtask

  task automatic holdCheck(input logic op, input int vl, input logic [MAX_VL*ELEM_W-1:0] src);
    logic [MAX_VL*CNT_W-1:0] eRes;
    logic [MAX_VL-1:0] eMsk;
    model(op, vl, src, eRes, eMsk);
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      opSel = ~opSel; srcVec = srcVec ^ 24'h5a5a5a; vecLen = VL_W'(c + 2);
    end
    @(posedge clk); #1;
    // R9: outputs hold after done
    chk(resS == eRes && resP == eRes, "R9 counts held", 32'(resS), 32'(eRes));
    chk(maskS == eMsk && maskP == eMsk, "R9 mask held", 32'(maskS), 32'(eMsk));
    chk(!doneS && !doneP, "R9 no spurious done", {30'd0, doneS, doneP}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [MAX_VL*ELEM_W-1:0] pat;
    seed = 32'h1234_5678;
    #(CLK_PERIOD * 3);
    #1;
    // R10: reset state
    chk(resS == '0 && resP == '0, "R10 reset counts", 32'(resS), 32'd0);
    chk(maskS == '0 && maskP == '0 && !doneS && !doneP, "R10 reset mask/done",
        {22'd0, doneS, doneP, maskS}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    for (int p = 0; p < 8; p++) begin
      case (p)
        0: pat = '0;
        1: for (int i = 0; i < MAX_VL; i++) pat[i*ELEM_W +: ELEM_W] = ELEM_W'(i);
        2: for (int i = 0; i < MAX_VL; i++) pat[i*ELEM_W +: ELEM_W] = ELEM_W'(i % 2);
        3: for (int i = 0; i < MAX_VL; i++) pat[i*ELEM_W +: ELEM_W] = ELEM_W'(7 - i / 3);
        default: begin
          seed = seed * 32'd1103515245 + 32'd12345;
          pat = seed[30:7];
        end
      endcase
      for (int vl = 0; vl <= 10; vl++) begin
        runCase(1'b0, vl, pat, 1'b0);
        runCase(1'b1, vl, pat, 1'b0);
      end
      runCase(1'b0, 15, pat, 1'b0);
    end
    // R7: a start during a run is ignored
    pat = 24'o31413252;
    runCase(1'b0, 8, pat, 1'b1);
    holdCheck(1'b0, 8, pat);
    runCase(1'b1, 8, pat, 1'b1);
    holdCheck(1'b1, 8, pat);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule